// File: doc/BRIEF.md
# Multichannel DAC Serial Register Controller

This block is the digital control core of a 32-channel voltage DAC that also carries one shared offset channel. A host shifts 32-bit command frames in over a three-wire serial link (serial clock, serial data, active-low frame select). The core samples those wires with its own system clock, counts the bits of each frame, and decodes the control, address and data fields of every complete frame.

Each of the 33 channels holds two registers in series. Serial writes land in the staging (input) register. The output (DAC) register changes only when the active-low load pin falls, which copies every staging register into its output register in the same cycle, or when a clear command arrives. The offset channel sits at address 32 and has its own output port, because its value shifts all 32 outputs together. Its code is held below a ceiling that depends on the gain variant, and it starts at a variant-selected default. The serial link has no back-pressure: a frame that is not exactly 32 bits long, or that finishes in the same cycle as a load, is dropped. Data and control pins are plain wires with no valid/ready handshake.

Top module: `dacctl_core`

## Requirements
- R1: A frame is sampled on rising serial-clock edges, MSB first, as control[31:29], address[28:23], unused[22:16] and data[15:0]. Control 3'b011 with an address from 0 to 31 writes data into that channel's staging register. The channel's output register does not change until a load.
- R2: Control 3'b011 with address 32 writes the offset channel's staging register. Its output register appears on `offset_code` after a load.
- R3: Writes to addresses 33 to 63, and frames whose control is neither 3'b011 nor 3'b100, change no register.
- R4: A frame is accepted only if exactly 32 rising serial-clock edges occur while frame select is low. A frame with 31 or 33 edges changes nothing.
- R5: A falling edge on the load pin (after a two-flop synchroniser) copies every staging register into its output register in one cycle. While the load pin stays high, no output register changes except by clear.
- R6: If a frame completes in the same cycle that the synchronised load edge fires, the load is performed and that frame is discarded.
- R7: An offset write above the ceiling stores the ceiling: 16384 when VARIANT is 0, and 40000 otherwise. A write equal to the ceiling is stored unchanged.
- R8: After reset, every ordinary channel holds 0 in both registers. The offset channel holds its default in both registers: 0x0000 for VARIANT 0 or 1, 0x4000 for VARIANT 2, and 0x8000 for VARIANT 3.
- R9: Control 3'b100 (clear) sets both registers of every ordinary channel to 0 and both offset registers to the default. The outputs change without a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| cs_n | input | 1 | Active-low frame select |
| ldac_n | input | 1 | Active-low load; its falling edge transfers all staging registers |
| dac_codes | output | NCH*16 | Output registers of the ordinary channels; channel i occupies bits [16*i+15:16*i] |
| offset_code | output | 16 | Output register of the shared offset channel |

## Verification
The hardest case to reach from the ports is a frame that completes in exactly the cycle the load edge fires (R6). The frame-select path and the load path use synchronisers of equal depth. The stimulus therefore shifts all 32 bits while keeping frame select low, then raises frame select and lowers the load pin at the same clock edge. That makes both events land in one cycle. A second load afterwards shows whether the dropped write ever reached the staging register.

// File: rtl/dacctl_pkg.sv
package dacctl_pkg;

  localparam int FRAME_W  = 32;
  localparam int CODE_W   = 16;
  localparam int ADDR_W   = 6;
  localparam int CTL_W    = 3;
  localparam int OFF_ADDR = 32;

  typedef enum logic [CTL_W-1:0] {
    CMD_WRITE = 3'b011,
    CMD_CLEAR = 3'b100
  } cmd_e;

  function automatic logic [CODE_W-1:0] offset_default(input logic [1:0] variant);
    case (variant)
      2'd2:    return 16'h4000;
      2'd3:    return 16'h8000;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] offset_ceiling(input logic [1:0] variant);
    return (variant == 2'd0) ? 16'd16384 : 16'd40000;
  endfunction

endpackage

// File: rtl/dacctl_frame_rx.sv
module dacctl_frame_rx
  import dacctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              cs_n,
  output logic              frame_vld,
  output logic [CTL_W-1:0]  frame_ctl,
  output logic [ADDR_W-1:0] frame_addr,
  output logic [CODE_W-1:0] frame_data
);

  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int CNT_SAT = FRAME_W + 1;

  logic [1:0]         sclk_s, sdi_s, cs_s;
  logic               sclk_q, cs_q;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;
  logic               sclk_rise, cs_rise, cs_fall, cs_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      sdi_s  <= '0;
      cs_s   <= '1;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_s <= {sclk_s[0], sclk};
      sdi_s  <= {sdi_s[0], sdi};
      cs_s   <= {cs_s[0], cs_n};
      sclk_q <= sclk_s[1];
      cs_q   <= cs_s[1];
    end
  end

  assign sclk_rise = sclk_s[1] & ~sclk_q;
  assign cs_rise   = cs_s[1] & ~cs_q;
  assign cs_fall   = ~cs_s[1] & cs_q;
  assign cs_active = ~cs_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
    end else if (cs_active && sclk_rise) begin
      shreg <= {shreg[FRAME_W-2:0], sdi_s[1]};
      if (bit_cnt != CNT_W'(CNT_SAT)) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign frame_vld  = cs_rise && (bit_cnt == CNT_W'(FRAME_W));
  assign frame_ctl  = shreg[FRAME_W-1 -: CTL_W];
  assign frame_addr = shreg[FRAME_W-1-CTL_W -: ADDR_W];
  assign frame_data = shreg[CODE_W-1:0];

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |=> !frame_vld);  // R4

endmodule

// File: rtl/dacctl_load_sync.sv
module dacctl_load_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ldac_n,
  output logic load_fire
);

  logic [1:0] ld_s;
  logic       ld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_s <= '1;
      ld_q <= 1'b1;
    end else begin
      ld_s <= {ld_s[0], ldac_n};
      ld_q <= ld_s[1];
    end
  end

  assign load_fire = ld_q & ~ld_s[1];

  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> !load_fire);  // R5

endmodule

// File: rtl/dacctl_regbank.sv
module dacctl_regbank
  import dacctl_pkg::*;
#(
  parameter int         NCH     = 32,
  parameter logic [1:0] VARIANT = 2'd2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_vld,
  input  logic [CTL_W-1:0]      frame_ctl,
  input  logic [ADDR_W-1:0]     frame_addr,
  input  logic [CODE_W-1:0]     frame_data,
  input  logic                  load_fire,
  output logic [NCH*CODE_W-1:0] dac_flat,
  output logic [CODE_W-1:0]     off_dac
);

  localparam logic [CODE_W-1:0] OFF_DEF  = offset_default(VARIANT);
  localparam logic [CODE_W-1:0] OFF_CEIL = offset_ceiling(VARIANT);

  logic [NCH*CODE_W-1:0] in_flat;
  logic [CODE_W-1:0]     off_in, off_wdata;
  logic                  wr_ok, do_write, do_clear;

  assign wr_ok     = frame_vld & ~load_fire;
  assign do_write  = wr_ok && (frame_ctl == CMD_WRITE);
  assign do_clear  = wr_ok && (frame_ctl == CMD_CLEAR);
  assign off_wdata = (frame_data > OFF_CEIL) ? OFF_CEIL : frame_data;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CODE_W-1:0] in_q, dac_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q  <= '0;
        dac_q <= '0;
      end else if (load_fire) begin
        dac_q <= in_q;
      end else if (do_clear) begin
        in_q  <= '0;
        dac_q <= '0;
      end else if (do_write && frame_addr == ADDR_W'(i)) begin
        in_q  <= frame_data;
      end
    end
    assign in_flat[i*CODE_W +: CODE_W]  = in_q;
    assign dac_flat[i*CODE_W +: CODE_W] = dac_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_in  <= OFF_DEF;
      off_dac <= OFF_DEF;
    end else if (load_fire) begin
      off_dac <= off_in;
    end else if (do_clear) begin
      off_in  <= OFF_DEF;
      off_dac <= OFF_DEF;
    end else if (do_write && frame_addr == ADDR_W'(OFF_ADDR)) begin
      off_in  <= off_wdata;
    end
  end

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> (dac_flat == $past(in_flat)) && (off_dac == $past(off_in)));  // R5

  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_fire && !(frame_vld && frame_ctl == CMD_CLEAR)) |=> $stable(dac_flat) && $stable(off_dac));  // R5

  AST_LOAD_DROPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire && frame_vld) |=> $stable(in_flat) && $stable(off_in));  // R6

  AST_OFFSET_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (off_in <= OFF_CEIL) && (off_dac <= OFF_CEIL));  // R7

  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && !load_fire && frame_ctl == CMD_CLEAR) |=>
      (dac_flat == '0) && (in_flat == '0) && (off_dac == OFF_DEF) && (off_in == OFF_DEF));  // R9

endmodule

// File: rtl/dacctl_core.sv
module dacctl_core
  import dacctl_pkg::*;
#(
  parameter int         NCH     = 32,
  parameter logic [1:0] VARIANT = 2'd2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  sdi,
  input  logic                  cs_n,
  input  logic                  ldac_n,
  output logic [NCH*CODE_W-1:0] dac_codes,
  output logic [CODE_W-1:0]     offset_code
);

  logic              frame_vld, load_fire;
  logic [CTL_W-1:0]  frame_ctl;
  logic [ADDR_W-1:0] frame_addr;
  logic [CODE_W-1:0] frame_data;

  dacctl_frame_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .sdi        (sdi),
    .cs_n       (cs_n),
    .frame_vld  (frame_vld),
    .frame_ctl  (frame_ctl),
    .frame_addr (frame_addr),
    .frame_data (frame_data)
  );

  dacctl_load_sync u_ld (
    .clk       (clk),
    .rst_n     (rst_n),
    .ldac_n    (ldac_n),
    .load_fire (load_fire)
  );

  dacctl_regbank #(.NCH(NCH), .VARIANT(VARIANT)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_vld  (frame_vld),
    .frame_ctl  (frame_ctl),
    .frame_addr (frame_addr),
    .frame_data (frame_data),
    .load_fire  (load_fire),
    .dac_flat   (dac_codes),
    .off_dac    (offset_code)
  );

endmodule

// File: tb/sim_dacctl_core.sv
module sim_dacctl_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        cs_n = 1'b1;
  logic        ldac_n = 1'b1;
  logic [511:0] dac_codes;
  logic [15:0]  offset_code;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  dacctl_core u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
    .ldac_n(ldac_n), .dac_codes(dac_codes), .offset_code(offset_code)
  );

  always #4ns clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ch(input int i);
    return dac_codes[i*16 +: 16];
  endfunction

  task automatic shift_bits(input logic [63:0] w, input int n);
    cs_n = 1'b0;
    wait_clk(4);
    for (int b = n - 1; b >= 0; b--) begin
      sdi = w[b];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
  endtask

  function automatic logic [31:0] mk(input logic [2:0] c, input logic [5:0] a, input logic [15:0] d);
    return {c, a, 7'h55, d};
  endfunction

  task automatic send(input logic [2:0] c, input logic [5:0] a, input logic [15:0] d);
    shift_bits({32'h0, mk(c, a, d)}, 32);
    cs_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic pulse_load();
    ldac_n = 1'b0;
    wait_clk(8);
    ldac_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 32; i++) check("R8 ordinary reset", ch(i), 16'h0000);
    check("R8 offset default", offset_code, 16'h4000);
  endtask

  task automatic t_write_load();
    send(3'b011, 6'd0, 16'h1234);
    send(3'b011, 6'd31, 16'hBEEF);
    send(3'b011, 6'd7, 16'h00FF);
    check("R1 no output before load", ch(0), 16'h0000);
    check("R1 no output before load ch31", ch(31), 16'h0000);
    wait_clk(40);
    check("R5 held while load high", ch(7), 16'h0000);
    pulse_load();
    check("R1 ch0 after load", ch(0), 16'h1234);
    check("R5 ch31 after load", ch(31), 16'hBEEF);
    check("R5 ch7 after load", ch(7), 16'h00FF);
  endtask

  task automatic t_offset();
    send(3'b011, 6'd32, 16'h1000);
    check("R2 offset before load", offset_code, 16'h4000);
    pulse_load();
    check("R2 offset after load", offset_code, 16'h1000);
    check("R2 ordinary untouched", ch(0), 16'h1234);
  endtask

  task automatic t_clamp();
    send(3'b011, 6'd32, 16'hFFFF);
    pulse_load();
    check("R7 clamp 0xFFFF", offset_code, 16'd40000);
    send(3'b011, 6'd32, 16'd40000);
    pulse_load();
    check("R7 at ceiling", offset_code, 16'd40000);
    send(3'b011, 6'd32, 16'd39999);
    pulse_load();
    check("R7 below ceiling", offset_code, 16'd39999);
    send(3'b011, 6'd32, 16'd40001);
    pulse_load();
    check("R7 clamp 40001", offset_code, 16'd40000);
  endtask

  task automatic t_ignored();
    send(3'b011, 6'd40, 16'h5555);
    send(3'b011, 6'd63, 16'h6666);
    send(3'b111, 6'd3, 16'h7777);
    send(3'b001, 6'd32, 16'h0123);
    pulse_load();
    check("R3 addr 40 not aliased", ch(8), 16'h0000);
    check("R3 addr 63 not aliased", ch(31), 16'hBEEF);
    check("R3 bad control ch3", ch(3), 16'h0000);
    check("R3 bad control offset", offset_code, 16'd40000);
  endtask

  task automatic t_badcount();
    logic [31:0] w;
    w = mk(3'b011, 6'd2, 16'hAAAA);
    shift_bits({32'h0, w}, 31);
    cs_n = 1'b1;
    wait_clk(10);
    shift_bits({31'h0, 1'b0, w}, 33);
    cs_n = 1'b1;
    wait_clk(10);
    pulse_load();
    check("R4 short/long frames dropped ch2", ch(2), 16'h0000);
    check("R4 short/long frames dropped ch0", ch(0), 16'h1234);
  endtask

  task automatic t_coincide();
    send(3'b011, 6'd5, 16'h1111);
    pulse_load();
    check("R6 setup ch5", ch(5), 16'h1111);
    shift_bits({32'h0, mk(3'b011, 6'd5, 16'h2222)}, 32);
    cs_n = 1'b1;
    ldac_n = 1'b0;
    wait_clk(8);
    ldac_n = 1'b1;
    wait_clk(8);
    check("R6 coincident load", ch(5), 16'h1111);
    pulse_load();
    check("R6 frame discarded", ch(5), 16'h1111);
  endtask

  task automatic t_clear();
    send(3'b100, 6'd9, 16'hFFFF);
    for (int i = 0; i < 32; i++) check("R9 clear output", ch(i), 16'h0000);
    check("R9 clear offset", offset_code, 16'h4000);
    pulse_load();
    check("R9 staging cleared ch0", ch(0), 16'h0000);
    check("R9 staging cleared ch31", ch(31), 16'h0000);
    check("R9 staging offset default", offset_code, 16'h4000);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_write_load();
    t_offset();
    t_clamp();
    t_ignored();
    t_badcount();
    t_coincide();
    t_clear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule